// File: doc/BRIEF.md
# Hamming-Protected State Register

This block holds one wide permutation state word (1600 bits by default) in a register protected by a single-error-correcting Hamming code. On a write, an encoder computes the check bits and stores a codeword that is 11 bits longer than the data at the default width. On a read, a decoder computes the syndrome of the stored word, inverts the bit the syndrome points at, and returns the recovered data bits. Each direction has its own enable and a one-cycle ready pulse.

Two status flags come with each read result. One reports that a single-bit error was found and repaired. The other reports a syndrome that points past the end of the codeword; this can only be caused by multiple errors. A fault-injection port lets a testbench invert one stored codeword bit per cycle, so the correction path can be exercised without any real upset. Reads never write back to the stored word.

Top module: `hamming_state_reg`

## Requirements
- R1: Codeword positions are numbered from 1. Check bit i sits at position 2^i. Data bit j fills the j-th position that is not a power of two, in ascending order. Check bit i is the even parity of every position whose index has bit i set. A word written and read back with no fault returns the written data, with `fix_flag` and `bad_flag` low.
- R2: `wr_rdy` is high in the cycle after a cycle with `wr_en` high, and low in the cycle after a cycle with `wr_en` low.
- R3: `rd_rdy` is high in the cycle after a cycle with `rd_en` high, and low otherwise. `rd_data` changes only in the cycle after `rd_en`, and holds its value in all other cycles.
- R4: If exactly one stored bit at any position 1..CW_W (check or data) has been inverted, a read returns the original data, and `fix_flag` is high together with `rd_rdy` for that one cycle.
- R5: The syndrome is the XOR of the position indices of all set bits of the stored word. If it exceeds CW_W, the read raises `bad_flag` (not `fix_flag`) and returns the stored data bits without any correction. The two flags are never high at once, and are high only with `rd_rdy`.
- R6: When `inj_en` is high, the stored bit at 1-based position `inj_pos` is inverted. An `inj_pos` of 0, or one above CW_W, changes nothing. A write in the same cycle wins, and the injection is dropped.
- R7: A read does not modify the stored word, so an error that has been corrected is reported again on every later read.
- R8: When `rst_n` is low at a clock edge, the stored word becomes all zeros (the codeword of zero data), and `rd_data`, `wr_rdy`, `rd_rdy`, `fix_flag` and `bad_flag` all become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Encode `wr_data` and store the codeword |
| wr_data | input | DATA_W | State word to store |
| wr_rdy | output | 1 | Pulses one cycle after a write |
| rd_en | input | 1 | Decode and correct the stored word |
| rd_data | output | DATA_W | Recovered state word |
| rd_rdy | output | 1 | Pulses when `rd_data` and the flags are valid |
| fix_flag | output | 1 | A single error was corrected on this read |
| bad_flag | output | 1 | Syndrome was out of range; data returned uncorrected |
| inj_en | input | 1 | Invert one stored codeword bit |
| inj_pos | input | CHK_W | 1-based codeword position to invert |

## Verification
The bench builds the block with DATA_W = 8. This gives a 12-bit codeword with 4 check bits and a 4-bit syndrome, whose values 13 to 15 lie outside the codeword. At that size, all 256 data values can be swept, each stored clean and then with every one of the 12 single-bit faults, against an encoder model computed in the bench. Every double fault whose syndrome falls outside the codeword is injected to reach the uncorrectable path. Injection at invalid positions, a write colliding with an injection, repeated reads and a mid-run reset are driven separately.

// File: rtl/hsr_pkg.sv
// hsr_pkg: shared sizing helpers for the Hamming-protected state register.
// Assumes data widths of at least 1 bit.
package hsr_pkg;

    // Smallest number of check bits m with 2^m >= data + m + 1.
    function automatic int calc_chk_w(input int data_w);
        int m;
        m = 1;
        while ((1 << m) < data_w + m + 1) m++;
        return m;
    endfunction

endpackage

// File: rtl/hsr_encoder.sv
// hsr_encoder: combinational Hamming encoder.
// It places the data bits in the codeword positions that are not powers of
// two, in ascending order. The check bit at position 2^i is the even parity
// of the positions with index bit i set. This is computed as the XOR of the
// indices of all set data bits. Bit k of the output holds position k+1.
module hsr_encoder #(
    parameter int DATA_W = 1600,
    parameter int CHK_W  = hsr_pkg::calc_chk_w(DATA_W),
    parameter int CW_W   = DATA_W + CHK_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);

    logic [CHK_W-1:0] par;

    // Scatter the data bits and fold their positions into the check vector.
    always_comb begin
        int k;
        k    = 0;
        par  = '0;
        cw_o = '0;
        for (int p = 1; p <= CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw_o[p-1] = data_i[k];
                if (data_i[k]) par = par ^ CHK_W'(p);
                k++;
            end
        end
        for (int i = 0; i < CHK_W; i++) cw_o[(1 << i) - 1] = par[i];
    end

endmodule

// File: rtl/hsr_decoder.sv
// hsr_decoder: combinational Hamming syndrome, correction and extraction.
// The syndrome is the XOR of the indices of all set codeword bits. A nonzero
// syndrome that is within the codeword inverts that position. A syndrome
// past the end of the codeword is reported and leaves the word untouched.
// Assumes the codeword layout of hsr_encoder.
module hsr_decoder #(
    parameter int DATA_W = 1600,
    parameter int CHK_W  = hsr_pkg::calc_chk_w(DATA_W),
    parameter int CW_W   = DATA_W + CHK_W
) (
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic              hit_o,
    output logic              bad_o
);

    logic [CHK_W-1:0] syn;
    logic [CW_W-1:0]  fixed;

    // Form the syndrome from the positions of all set bits.
    always_comb begin
        syn = '0;
        for (int p = 1; p <= CW_W; p++) begin
            if (cw_i[p-1]) syn = syn ^ CHK_W'(p);
        end
    end

    // Classify the syndrome and repair the bit it points at.
    always_comb begin
        hit_o = (syn != '0) && (int'(syn) <= CW_W);
        bad_o = int'(syn) > CW_W;
        fixed = cw_i;
        if (hit_o) fixed[int'(syn) - 1] = ~cw_i[int'(syn) - 1];
    end

    // Gather the data bits back from the positions that are not powers of two.
    always_comb begin
        int k;
        k      = 0;
        data_o = '0;
        for (int p = 1; p <= CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                data_o[k] = fixed[p-1];
                k++;
            end
        end
    end

    // A syndrome cannot be both correctable and out of range (R5).
    always_comb begin
        a_flag_split_r5: assert (!(hit_o && bad_o));
    end

endmodule

// File: rtl/hsr_store.sv
// hsr_store: codeword register with a single-bit fault-injection path.
// A write loads a fresh codeword. Otherwise, an injection at a valid 1-based
// position inverts that one bit. Assumes a synchronous active-low reset,
// which clears the word to all zeros (the codeword of zero data).
module hsr_store #(
    parameter int CHK_W = 11,
    parameter int CW_W  = 1611
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CW_W-1:0]  wr_cw,
    input  logic             inj_en,
    input  logic [CHK_W-1:0] inj_pos,
    output logic [CW_W-1:0]  cw_q
);

    logic             pos_ok;
    logic [CW_W-1:0]  flip_mask;

    // Build a one-hot mask for an in-range injection position.
    always_comb begin
        pos_ok    = (inj_pos != '0) && (int'(inj_pos) <= CW_W);
        flip_mask = '0;
        if (pos_ok) flip_mask[int'(inj_pos) - 1] = 1'b1;
    end

    // Hold the codeword; a write wins over an injection.
    always_ff @(posedge clk) begin
        if (!rst_n)      cw_q <= '0;
        else if (wr_en)  cw_q <= wr_cw;
        else if (inj_en) cw_q <= cw_q ^ flip_mask;
    end

    p_inj_one_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_en && !wr_en && pos_ok) |=> ($countones(cw_q ^ $past(cw_q)) == 1));

    p_quiet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(inj_en && pos_ok)) |=> $stable(cw_q));

endmodule

// File: rtl/hamming_state_reg.sv
// hamming_state_reg: wide state register under a single-error-correcting
// Hamming code. A write encodes and stores the word, and wr_rdy follows one
// cycle later. A read decodes the stored word, then registers the data and
// flags, and rd_rdy follows one cycle later. Reads never write back.
// Assumes a synchronous active-low reset.
module hamming_state_reg #(
    parameter int DATA_W = 1600,
    parameter int CHK_W  = hsr_pkg::calc_chk_w(DATA_W),
    parameter int CW_W   = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_rdy,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_rdy,
    output logic              fix_flag,
    output logic              bad_flag,
    input  logic              inj_en,
    input  logic [CHK_W-1:0]  inj_pos
);

    logic [CW_W-1:0]   enc_cw;
    logic [CW_W-1:0]   cw_q;
    logic [DATA_W-1:0] dec_data;
    logic              dec_hit;
    logic              dec_bad;

    hsr_encoder #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_enc (
        .data_i (wr_data),
        .cw_o   (enc_cw)
    );

    hsr_store #(.CHK_W(CHK_W), .CW_W(CW_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_cw   (enc_cw),
        .inj_en  (inj_en),
        .inj_pos (inj_pos),
        .cw_q    (cw_q)
    );

    hsr_decoder #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_dec (
        .cw_i   (cw_q),
        .data_o (dec_data),
        .hit_o  (dec_hit),
        .bad_o  (dec_bad)
    );

    // Pulse the write handshake one cycle after the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_rdy <= 1'b0;
        else        wr_rdy <= wr_en;
    end

    // Register the read result and flags; rd_data holds between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_rdy   <= 1'b0;
            fix_flag <= 1'b0;
            bad_flag <= 1'b0;
        end else begin
            rd_rdy   <= rd_en;
            fix_flag <= rd_en && dec_hit;
            bad_flag <= rd_en && dec_bad;
            if (rd_en) rd_data <= dec_data;
        end
    end

    p_wr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> wr_rdy);

    p_wr_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_rdy);

    p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_rdy);

    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(rd_data) && !rd_rdy));

    p_flag_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_flag || bad_flag) |-> (rd_rdy && $onehot0({fix_flag, bad_flag})));

    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (!wr_rdy && !rd_rdy && !fix_flag && !bad_flag && (rd_data == '0)));

endmodule

// File: tb/sim_hamming_state_reg.sv
// sim_hamming_state_reg: sweep bench for an 8-bit configuration (12-bit codeword).
module sim_hamming_state_reg;

    localparam int DW = 8;
    localparam int CK = 4;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_rdy;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_rdy;
    logic          fix_flag;
    logic          bad_flag;
    logic          inj_en = 1'b0;
    logic [CK-1:0] inj_pos = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    hamming_state_reg #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .wr_rdy(wr_rdy),
        .rd_en(rd_en), .rd_data(rd_data), .rd_rdy(rd_rdy),
        .fix_flag(fix_flag), .bad_flag(bad_flag),
        .inj_en(inj_en), .inj_pos(inj_pos)
    );

    always #4 clk = ~clk;

    // Model encoder built from R1.
    function automatic logic [CW-1:0] model_enc(input logic [DW-1:0] d);
        logic [CW-1:0] w;
        int k;
        w = '0;
        k = 0;
        for (int p = 1; p <= CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                w[p-1] = d[k];
                k++;
            end
        end
        for (int i = 0; i < CK; i++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p <= CW; p++) begin
                if (((p >> i) & 1) == 1 && p != (1 << i)) par = par ^ w[p-1];
            end
            w[(1 << i) - 1] = par;
        end
        return w;
    endfunction

    // Raw data bits of a codeword, without correction.
    function automatic logic [DW-1:0] model_raw(input logic [CW-1:0] w);
        logic [DW-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p <= CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = w[p-1];
                k++;
            end
        end
        return d;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write a word; the ready pulse must appear for exactly one cycle (R2).
    task automatic do_write(input logic [DW-1:0] d, input bit probe);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (probe) begin
            chk("R2 wr_rdy high", 32'(wr_rdy), 32'd1);
            @(negedge clk);
            chk("R2 wr_rdy low", 32'(wr_rdy), 32'd0);
        end
    endtask

    task automatic inject(input int pos);
        @(negedge clk);
        inj_en = 1'b1;
        inj_pos = CK'(pos);
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    // Read and compare {rd_rdy, fix, bad, data}.
    task automatic do_read(input string req, input logic [DW-1:0] d, input logic f, input logic b);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, {21'd0, rd_rdy, fix_flag, bad_flag, rd_data}, {21'd0, 1'b1, f, b, d});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: outputs are clear while in reset
        chk("R8 reset outputs", {22'd0, wr_rdy, rd_rdy, fix_flag, bad_flag, rd_data},
            32'd0);
        rst_n = 1'b1;
        do_read("R8 reset word reads zero", 8'h00, 1'b0, 1'b0);

        do_write(8'h3C, 1'b1);

        // R1, R4: exhaustive clean and single-fault sweep
        for (int d = 0; d < 256; d++) begin
            do_write(DW'(d), 1'b0);
            do_read("R1 clean readback", DW'(d), 1'b0, 1'b0);
            for (int p = 1; p <= CW; p++) begin
                do_write(DW'(d), 1'b0);
                inject(p);
                do_read("R4 single fault corrected", DW'(d), 1'b1, 1'b0);
            end
        end

        // R5: double faults whose syndrome exceeds the codeword length
        for (int a = 1; a <= CW; a++) begin
            for (int b = a + 1; b <= CW; b++) begin
                if ((a ^ b) > CW) begin
                    logic [CW-1:0] w;
                    w = model_enc(8'hA5);
                    w[a-1] = ~w[a-1];
                    w[b-1] = ~w[b-1];
                    do_write(8'hA5, 1'b0);
                    inject(a);
                    inject(b);
                    do_read("R5 uncorrectable raw data", model_raw(w), 1'b0, 1'b1);
                end
            end
        end

        // R6: invalid positions are ignored
        do_write(8'h5A, 1'b0);
        inject(0);
        inject(13);
        inject(15);
        do_read("R6 invalid positions ignored", 8'h5A, 1'b0, 1'b0);

        // R6: a write in the same cycle drops the injection
        do_write(8'h11, 1'b0);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'hC3;
        inj_en = 1'b1;
        inj_pos = 4'd5;
        @(negedge clk);
        wr_en = 1'b0;
        inj_en = 1'b0;
        do_read("R6 write beats injection", 8'hC3, 1'b0, 1'b0);

        // R7: a read does not scrub the stored word
        do_write(8'h96, 1'b0);
        inject(7);
        do_read("R7 first read", 8'h96, 1'b1, 1'b0);
        do_read("R7 repeat read", 8'h96, 1'b1, 1'b0);

        // R3: rd_data holds and rd_rdy stays low between reads
        do_write(8'h01, 1'b0);
        repeat (3) @(negedge clk);
        chk("R3 hold between reads", {23'd0, rd_rdy, rd_data}, {23'd0, 1'b0, 8'h96});

        // R8: reset mid-run clears the stored word
        do_write(8'hFF, 1'b0);
        inject(3);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R8 mid-run reset outputs", {23'd0, rd_rdy, rd_data}, 32'd0);
        do_read("R8 mid-run reset word", 8'h00, 1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule